// File: doc/BRIEF.md
# Polled Entropy Status Register

This block sits between a conditioned noise producer and a processor's CSR port. It holds at most one complete 16-bit random word. When the processor polls it, the block returns a 32-bit result in the same cycle and never stalls. The result carries a two-bit operational status in bits [31:30]. When the status reports fresh data, bits [15:0] carry the random value, and that value is wiped as the poll completes. No word can therefore be handed out twice.

A phase controller governs the status. After reset it runs a start-up self-test of `ST_CYCLES` clock cycles and then enters live operation. A non-fatal alarm sends it back to self-test, and that indication stays latched until a poll has observed it. A fatal alarm, or a self-test failure, parks it in a terminal fault state. A test-enable bit holds the block in self-test and wipes the held word. Once that bit is cleared, the block runs a full new self-test.

Access is checked on every poll. Machine mode is always allowed. Supervisor and user modes are allowed only when their enable bits in the security configuration word are set. Any access that would not write, or that comes from a mode without rights, takes an illegal-instruction trap and leaves the held word untouched.

Top module: `entropy_poll_csr`

## Requirements
- R1: Only address 0x015 is decoded. Any other address gives `rsp_hit`=0, `rsp_trap`=0 and `rsp_data`=0, and consumes nothing.
- R2: The status codes in `rsp_data[31:30]` are 00 self-test, 01 waiting, 10 data ready and 11 dead. With status 10, bits [15:0] hold the random word and bits [29:16] are zero.
- R3: Under any status other than data ready, all of `rsp_data[29:0]` is zero.
- R4: A granted poll that returns data empties the holding register. The next poll reports waiting unless a new word has arrived in between.
- R5: `nz_ready` is high only while the block is live and the holding register is empty. A word offered while the register is full is dropped, and the held word is kept.
- R6: A poll is answered combinationally in the cycle it is presented. With no word held, the answer is waiting (0x40000000).
- R7: `csr_op` encodes 01 for write, 10 for set and 11 for clear. A set or clear with `csr_src_zero`=1, or op 00, traps with `rsp_data`=0 and does not consume the held word.
- R8: `csr_priv` encodes 11 machine, 01 supervisor and 00 user. Machine mode is always granted. Supervisor needs `sec_cfg[9]` and user needs `sec_cfg[8]`. Every other case traps.
- R9: After reset the status is self-test. It becomes waiting exactly `ST_CYCLES` rising edges after the last reset edge.
- R10: `st_fail` asserted during self-test moves the block to dead (0xC0000000).
- R11: `alarm_soft` while live wipes the held word and returns the status to self-test. The status stays self-test, even after a new self-test completes, until a granted poll has observed it.
- R12: `alarm_fatal` moves the block to dead. Dead is left only by reset, returns no data and keeps `nz_ready` low.
- R13: While `test_ctl[31]` is set, the status is self-test and no word is accepted. After the bit clears, waiting returns exactly `ST_CYCLES` edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | CSR access strobe |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | Access form: 01 write, 10 set, 11 clear |
| csr_src_zero | input | 1 | Source register or immediate is zero |
| csr_priv | input | 2 | Current privilege: 11 M, 01 S, 00 U |
| sec_cfg | input | 32 | Security configuration; bit 9 supervisor enable, bit 8 user enable |
| test_ctl | input | 32 | Test control; bit 31 enables test mode |
| nz_valid | input | 1 | Producer offers a word |
| nz_word | input | 16 | Conditioned noise word |
| nz_ready | output | 1 | Holding register can take a word |
| st_fail | input | 1 | Self-test failure strobe |
| alarm_soft | input | 1 | Non-fatal health alarm strobe |
| alarm_fatal | input | 1 | Fatal health alarm strobe |
| rsp_hit | output | 1 | Access addressed this register |
| rsp_trap | output | 1 | Illegal-instruction trap for this access |
| rsp_data | output | 32 | Poll result |

## Verification
The assertions assume that the access fields are stable for the whole cycle in which `csr_req` is high. They also assume that `csr_priv` takes only the three listed encodings and that alarm strobes last one cycle each. The bench drives every input at the falling clock edge and presents one poll at a time, deasserting the request after a single cycle. Alarm and failure strobes are pulsed for exactly one cycle, each at a point where the phase it targets is known. Producer words are offered for one cycle, so whether a word is accepted or dropped depends only on the holding state at that edge.

// File: rtl/ent_pkg.sv
package ent_pkg;

    localparam int NOISE_W     = 16;
    localparam int CFG_S_BIT   = 9;
    localparam int CFG_U_BIT   = 8;
    localparam int TEST_EN_BIT = 31;
    localparam logic [11:0] SEED_ADDR = 12'h015;

    // Status codes placed in result bits [31:30]
    typedef enum logic [1:0] {
        ST_BIST = 2'b00,
        ST_WAIT = 2'b01,
        ST_ES16 = 2'b10,
        ST_DEAD = 2'b11
    } opst_e;

    typedef enum logic [1:0] {
        PH_BIST = 2'b00,
        PH_LIVE = 2'b01,
        PH_DEAD = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RW   = 2'b01,
        OP_RS   = 2'b10,
        OP_RC   = 2'b11
    } csrop_e;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_R = 2'b10,
        PRIV_M = 2'b11
    } priv_e;

    typedef struct packed {
        logic hit;
        logic grant;
        logic trap;
    } acc_s;

    function automatic logic [31:0] pack_result(opst_e st, logic [NOISE_W-1:0] w);
        logic [31:0] r;
        r = '0;
        r[31:30] = st;
        if (st == ST_ES16) r[NOISE_W-1:0] = w;
        return r;
    endfunction

endpackage

// File: rtl/ent_access.sv
module ent_access
    import ent_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        op,
    input  logic              src_zero,
    input  logic [1:0]        priv,
    input  logic              s_en,
    input  logic              u_en,
    output acc_s              acc
);
    logic hit, writes, priv_ok;

    always_comb begin
        hit = req && (addr == ADDR_W'(SEED_ADDR));
        unique case (csrop_e'(op))
            OP_RW:        writes = 1'b1;
            OP_RS, OP_RC: writes = !src_zero;
            default:      writes = 1'b0;
        endcase
        unique case (priv_e'(priv))
            PRIV_M:  priv_ok = 1'b1;
            PRIV_S:  priv_ok = s_en;
            PRIV_U:  priv_ok = u_en;
            default: priv_ok = 1'b0;
        endcase
        acc.hit   = hit;
        acc.grant = hit && writes && priv_ok;
        acc.trap  = hit && !(writes && priv_ok);
    end
endmodule

// File: rtl/ent_phase.sv
module ent_phase
    import ent_pkg::*;
#(
    parameter int ST_CYCLES = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   test_en,
    input  logic   st_fail,
    input  logic   alarm_soft,
    input  logic   alarm_fatal,
    input  logic   poll,
    output phase_e phase
);
    localparam int CW = (ST_CYCLES < 2) ? 1 : $clog2(ST_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(ST_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          alarm_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_BIST;
            cnt        <= '0;
            alarm_seen <= 1'b0;
        end else if (alarm_fatal || phase == PH_DEAD) begin
            phase <= PH_DEAD;
        end else if (test_en) begin
            phase <= PH_BIST;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_BIST: begin
                    if (st_fail) begin
                        phase <= PH_DEAD;
                    end else begin
                        if (poll) alarm_seen <= 1'b0;
                        if (cnt != LAST) cnt <= cnt + 1'b1;
                        else if (!alarm_seen) phase <= PH_LIVE;
                    end
                end
                PH_LIVE: begin
                    if (alarm_soft) begin
                        phase      <= PH_BIST;
                        cnt        <= '0;
                        alarm_seen <= 1'b1;
                    end
                end
                default: phase <= PH_DEAD;
            endcase
        end
    end

    // R12
    dead_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_DEAD |=> phase == PH_DEAD);

    // R13
    test_hold_chk: assert property (@(posedge clk) disable iff (rst)
        test_en |=> phase != PH_LIVE);

    // R11
    alarm_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BIST && alarm_seen && !poll) |=> phase != PH_LIVE);
endmodule

// File: rtl/ent_hold.sv
module ent_hold
    import ent_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               live,
    input  logic               in_valid,
    input  logic [NOISE_W-1:0] in_word,
    input  logic               consume,
    output logic               ready,
    output logic               full,
    output logic [NOISE_W-1:0] word
);
    assign ready = live && !full;

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            full <= 1'b0;
            word <= '0;
        end else if (consume) begin
            full <= 1'b0;
            word <= '0;
        end else if (in_valid && ready) begin
            full <= 1'b1;
            word <= in_word;
        end
    end

    // R4
    wipe_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        consume |=> !full);

    // R5
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (live && full && !consume) |=> (full && $stable(word)));
endmodule

// File: rtl/entropy_poll_csr.sv
module entropy_poll_csr
    import ent_pkg::*;
#(
    parameter int ST_CYCLES = 16,
    parameter int ADDR_W    = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_req,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [1:0]         csr_op,
    input  logic               csr_src_zero,
    input  logic [1:0]         csr_priv,
    input  logic [31:0]        sec_cfg,
    input  logic [31:0]        test_ctl,
    input  logic               nz_valid,
    input  logic [NOISE_W-1:0] nz_word,
    output logic               nz_ready,
    input  logic               st_fail,
    input  logic               alarm_soft,
    input  logic               alarm_fatal,
    output logic               rsp_hit,
    output logic               rsp_trap,
    output logic [31:0]        rsp_data
);
    acc_s               acc;
    phase_e             phase;
    opst_e              status;
    logic               full, consume;
    logic [NOISE_W-1:0] word;
    logic               unused_bits;

    assign unused_bits = ^{sec_cfg[31:10], sec_cfg[7:0], test_ctl[30:0]};

    ent_access #(.ADDR_W(ADDR_W)) u_acc (
        .req      (csr_req),
        .addr     (csr_addr),
        .op       (csr_op),
        .src_zero (csr_src_zero),
        .priv     (csr_priv),
        .s_en     (sec_cfg[CFG_S_BIT]),
        .u_en     (sec_cfg[CFG_U_BIT]),
        .acc      (acc)
    );

    ent_phase #(.ST_CYCLES(ST_CYCLES)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .test_en     (test_ctl[TEST_EN_BIT]),
        .st_fail     (st_fail),
        .alarm_soft  (alarm_soft),
        .alarm_fatal (alarm_fatal),
        .poll        (acc.grant),
        .phase       (phase)
    );

    ent_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .live     (phase == PH_LIVE),
        .in_valid (nz_valid),
        .in_word  (nz_word),
        .consume  (consume),
        .ready    (nz_ready),
        .full     (full),
        .word     (word)
    );

    always_comb begin
        unique case (phase)
            PH_LIVE: status = full ? ST_ES16 : ST_WAIT;
            PH_BIST: status = ST_BIST;
            default: status = ST_DEAD;
        endcase
    end

    assign consume  = acc.grant && (status == ST_ES16);
    assign rsp_hit  = acc.hit;
    assign rsp_trap = acc.trap;
    assign rsp_data = acc.grant ? pack_result(status, word) : 32'h0;

    // R3
    no_stale_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && rsp_data[31:30] != 2'b10) |-> rsp_data[29:0] == 30'h0);

    // R7
    trap_silent_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_data == 32'h0 && rsp_hit));

    // R12
    dead_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && rsp_data[31:30] == 2'b11) |-> !nz_ready);

    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_data == 32'h0 && !rsp_trap));
endmodule

// File: tb/entropy_poll_csr_tb.sv
module entropy_poll_csr_tb;
    localparam int ST = 16;
    localparam logic [11:0] A_SEED = 12'h015;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_req = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = 2'b01;
    logic        csr_src_zero = 1'b0;
    logic [1:0]  csr_priv = 2'b11;
    logic [31:0] sec_cfg = '0;
    logic [31:0] test_ctl = '0;
    logic        nz_valid = 1'b0;
    logic [15:0] nz_word = '0;
    logic        nz_ready;
    logic        st_fail = 1'b0;
    logic        alarm_soft = 1'b0;
    logic        alarm_fatal = 1'b0;
    logic        rsp_hit, rsp_trap;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    logic [33:0] exp_q[$];
    string       tag_q[$];
    event        mon_ev;

    entropy_poll_csr #(.ST_CYCLES(ST)) u_dut (
        .clk(clk), .rst(rst), .csr_req(csr_req), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_src_zero(csr_src_zero), .csr_priv(csr_priv),
        .sec_cfg(sec_cfg), .test_ctl(test_ctl), .nz_valid(nz_valid),
        .nz_word(nz_word), .nz_ready(nz_ready), .st_fail(st_fail),
        .alarm_soft(alarm_soft), .alarm_fatal(alarm_fatal),
        .rsp_hit(rsp_hit), .rsp_trap(rsp_trap), .rsp_data(rsp_data)
    );

    always #10 clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    // Scoreboard monitor
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                logic [33:0] e;
                logic [33:0] g;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                g = {rsp_hit, rsp_trap, rsp_data};
                checks++;
                if (g !== e) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b trap=%0b data=%h expected hit=%0b trap=%0b data=%h",
                             t, g[33], g[32], g[31:0], e[33], e[32], e[31:0]);
                end
            end
        end
    end

    task automatic check_bit(logic act, logic exp, string t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", t, act, exp);
        end
    endtask

    // Driver: called at a falling edge, holds the poll for one cycle
    task automatic poll(logic [11:0] a, logic [1:0] op, logic sz, logic [1:0] pv,
                        logic [31:0] cfg, logic eh, logic et, logic [31:0] ed, string t);
        csr_req = 1'b1; csr_addr = a; csr_op = op; csr_src_zero = sz;
        csr_priv = pv; sec_cfg = cfg;
        exp_q.push_back({eh, et, ed});
        tag_q.push_back(t);
        #5;
        -> mon_ev;
        @(negedge clk);
        csr_req = 1'b0;
    endtask

    task automatic mpoll(logic [31:0] ed, string t);
        poll(A_SEED, 2'b01, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, ed, t);
    endtask

    task automatic offer(logic [15:0] w);
        nz_valid = 1'b1; nz_word = w;
        @(negedge clk);
        nz_valid = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R9: self-test right after reset, then exact exit edge
        mpoll(32'h0000_0000, "R9 reset bist");
        repeat (ST - 2) @(negedge clk);
        mpoll(32'h0000_0000, "R9 bist before edge ST");
        // R6: immediate waiting answer
        mpoll(32'h4000_0000, "R9 R6 waiting at edge ST");
        #1 check_bit(nz_ready, 1'b1, "R5 ready when empty");
        @(negedge clk);

        // R2 R4 R5
        offer(16'hABCD);
        #1 check_bit(nz_ready, 1'b0, "R5 not ready when full");
        @(negedge clk);
        offer(16'h1234);
        mpoll(32'h8000_ABCD, "R2 R5 first word kept");
        mpoll(32'h4000_0000, "R4 wiped after read");

        // R7: read-only forms trap without consuming
        offer(16'h5A5A);
        poll(A_SEED, 2'b10, 1'b1, 2'b11, 32'h0, 1'b1, 1'b1, 32'h0, "R7 set zero src traps");
        poll(A_SEED, 2'b00, 1'b0, 2'b11, 32'h0, 1'b1, 1'b1, 32'h0, "R7 op none traps");
        poll(A_SEED, 2'b11, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 32'h8000_5A5A, "R7 clear nonzero src ok");

        // R1 R8
        offer(16'h0F0F);
        poll(12'h016, 2'b01, 1'b0, 2'b11, 32'h0, 1'b0, 1'b0, 32'h0, "R1 other address");
        poll(A_SEED, 2'b01, 1'b0, 2'b01, 32'h0, 1'b1, 1'b1, 32'h0, "R8 S without enable");
        poll(A_SEED, 2'b01, 1'b0, 2'b01, 32'h200, 1'b1, 1'b0, 32'h8000_0F0F, "R8 S with bit9");
        offer(16'h7777);
        poll(A_SEED, 2'b01, 1'b0, 2'b00, 32'h200, 1'b1, 1'b1, 32'h0, "R8 U with bit9 only");
        poll(A_SEED, 2'b01, 1'b0, 2'b10, 32'h300, 1'b1, 1'b1, 32'h0, "R8 reserved mode");
        poll(A_SEED, 2'b01, 1'b0, 2'b00, 32'h100, 1'b1, 1'b0, 32'h8000_7777, "R8 U with bit8");

        // R11: soft alarm latched until polled, word wiped
        offer(16'h1111);
        pulse(alarm_soft);
        #1 check_bit(nz_ready, 1'b0, "R11 no intake after alarm");
        @(negedge clk);
        repeat (ST + 2) @(negedge clk);
        mpoll(32'h0000_0000, "R11 latched bist");
        mpoll(32'h0000_0000, "R11 one edge after poll");
        mpoll(32'h4000_0000, "R11 live again word wiped");

        // R13: test mode
        test_ctl = 32'h8000_0000;
        @(negedge clk);
        offer(16'h2222);
        mpoll(32'h0000_0000, "R13 bist in test mode");
        #1 check_bit(nz_ready, 1'b0, "R13 no intake in test mode");
        @(negedge clk);
        test_ctl = 32'h0;
        repeat (ST - 1) @(negedge clk);
        mpoll(32'h0000_0000, "R13 bist before new self-test ends");
        mpoll(32'h4000_0000, "R13 waiting after self-test");

        // R10: self-test failure
        do_reset();
        @(negedge clk);
        pulse(st_fail);
        mpoll(32'hC000_0000, "R10 dead after self-test fail");

        // R12: fatal alarm
        do_reset();
        repeat (ST) @(negedge clk);
        offer(16'h3333);
        pulse(alarm_fatal);
        mpoll(32'hC000_0000, "R12 dead no data");
        #1 check_bit(nz_ready, 1'b0, "R12 ready low in dead");
        @(negedge clk);
        test_ctl = 32'h8000_0000;
        @(negedge clk);
        test_ctl = 32'h0;
        repeat (ST + 2) @(negedge clk);
        mpoll(32'hC000_0000, "R12 dead is permanent");

        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule